// File: doc/BRIEF.md
# Dual-Lane ADC Frame Reader

This block sits on the host side of a simultaneous-sampling, two-channel converter. It is the master of the serial link. On a start strobe it pulls the chip select low and runs a fixed number of serial clock periods. The first part of that frame is the conversion interval, during which both data lanes float and carry nothing useful. The block then shifts in one 14-bit result from each of the two lanes on the same clock edges. When the frame ends it returns both words together with a one-cycle valid pulse.

A configuration word goes out on the DIN line during each frame. The block also does three other jobs:
- It pulses the calibrate pin on request.
- It keeps the chip select high for a minimum time between frames.
- It refuses to start any frame until a power-up wait after reset has elapsed.

Every time interval is a parameter counted in system-clock cycles. The serial clock comes from a divider of the system clock. It idles high and has a 50% duty cycle.

Top module: `dual_lane_adc_reader`

## Requirements
- R1: After reset, cs_n=1, sclk=1, din=0, cal=0 and res_valid=0. No frame starts until the power-up wait has elapsed. The wait is PWRUP_INT_CYC cycles when USE_INT_REF=1 and PWRUP_EXT_CYC cycles otherwise, and a start during the wait is ignored.
- R2: A start seen while idle drives cs_n low on the next clock edge. cs_n then stays low for exactly (2*(CONV_SCLKS+RES_W)+1)*SCLK_HALF clock cycles.
- R3: sclk is high whenever cs_n is high. During a frame, sclk toggles every SCLK_HALF cycles. The first falling edge comes SCLK_HALF cycles after cs_n falls, and a frame holds CONV_SCLKS+RES_W low pulses.
- R4: Lane inputs are ignored, both outside a frame and before the rising sclk edge that follows falling edge number CONV_SCLKS.
- R5: Each lane is sampled at the rising sclk edges that follow falling edges CONV_SCLKS through CONV_SCLKS+RES_W-1. The first sample is the MSB. Both lanes are sampled on the same edges.
- R6: res_valid is high for exactly one cycle, in the cycle where cs_n has just risen, and carries both words. res_a and res_b do not change at any other time.
- R7: din carries DIN_WORD MSB first. The bit for falling edge n is present from the cs_n fall (n=1) or from the rising edge after falling edge n-1. din is 0 after DIN_W bits and whenever cs_n is high.
- R8: After cs_n rises, the block stays busy for max(QUIET_CYC, CS_MIN_HIGH_CYC) cycles, and a start in that window is ignored.
- R9: A cal_req seen while idle raises cal for CAL_HIGH_CYC cycles. CAL_GAP_CYC further cycles then pass before a start is accepted. If cal_req and start arrive in the same idle cycle, cal_req wins.
- R10: Start and cal_req are ignored during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run one conversion frame |
| cal_req | input | 1 | Request for a calibrate pulse |
| lane_a | input | 1 | Serial data from converter channel A |
| lane_b | input | 1 | Serial data from converter channel B |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Configuration data to the converter |
| cal | output | 1 | Calibrate pin drive |
| res_a | output | RES_W | Last result from channel A |
| res_b | output | RES_W | Last result from channel B |
| res_valid | output | 1 | One-cycle pulse when both results update |

## Verification
The hardest case to reach from the ports is a start that lands exactly on the edge of a closed window: the last cycle of the quiet gap, a calibrate gap, or the power-up wait. Holding start high across the end of a frame reaches that boundary. So does issuing cal_req and start in the same cycle.

The converter model also drives random values on both lanes whenever the bits are not meant to be sampled. This means any sample taken on the wrong edge corrupts the returned words.

// File: rtl/dual_lane_adc_reader.sv
module dual_lane_adc_reader #(
  parameter int RES_W           = 14,
  parameter int CONV_SCLKS      = 19,
  parameter int SCLK_HALF       = 2,
  parameter int DIN_W           = 16,
  parameter logic [DIN_W-1:0] DIN_WORD = '0,
  parameter int QUIET_CYC       = 3,
  parameter int CS_MIN_HIGH_CYC = 2,
  parameter int CAL_HIGH_CYC    = 100,
  parameter int CAL_GAP_CYC     = 100,
  parameter int PWRUP_INT_CYC   = 12000,
  parameter int PWRUP_EXT_CYC   = 750,
  parameter bit USE_INT_REF     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cal_req,
  input  logic             lane_a,
  input  logic             lane_b,
  output logic             cs_n,
  output logic             sclk,
  output logic             din,
  output logic             cal,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             res_valid
);

  localparam int NSCLK  = CONV_SCLKS + RES_W;
  localparam int LAST_H = 2 * NSCLK;
  localparam int PWRUP  = USE_INT_REF ? PWRUP_INT_CYC : PWRUP_EXT_CYC;
  localparam int GAP    = (QUIET_CYC > CS_MIN_HIGH_CYC) ? QUIET_CYC : CS_MIN_HIGH_CYC;
  localparam int M1     = (PWRUP > GAP) ? PWRUP : GAP;
  localparam int M2     = (CAL_HIGH_CYC > CAL_GAP_CYC) ? CAL_HIGH_CYC : CAL_GAP_CYC;
  localparam int MAXC   = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int HW     = $clog2(LAST_H + 2);
  localparam int DVW    = $clog2(SCLK_HALF + 1);

  localparam logic [CW-1:0]  PWRUP_M1 = CW'(PWRUP - 1);
  localparam logic [CW-1:0]  GAP_M1   = CW'(GAP - 1);
  localparam logic [CW-1:0]  CALH_M1  = CW'(CAL_HIGH_CYC - 1);
  localparam logic [CW-1:0]  CALG_M1  = CW'(CAL_GAP_CYC - 1);
  localparam logic [DVW-1:0] DIV_M1   = DVW'(SCLK_HALF - 1);
  localparam logic [HW-1:0]  H_LAST   = HW'(LAST_H);
  localparam logic [HW-1:0]  CAP_LO   = HW'(CONV_SCLKS);
  localparam logic [HW-1:0]  CAP_HI   = HW'(CONV_SCLKS + RES_W - 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_CALH, S_CALG, S_FRAME, S_GAP} state_t;

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [DVW-1:0]   div;
  logic [HW-1:0]    h;
  logic             cs_q, sclk_q, cal_q, valid_q;
  logic [DIN_W-1:0] din_sr;
  logic [RES_W-1:0] sh_a, sh_b, ra_q, rb_q;

  logic [HW-1:0] h_nx, m_nx;
  logic          tick, cap;

  assign tick = (div == DIV_M1);
  assign h_nx = h + 1'b1;
  assign m_nx = h_nx >> 1;
  assign cap  = h[0] && (m_nx >= CAP_LO) && (m_nx <= CAP_HI);

  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign din       = ~cs_q & din_sr[DIN_W-1];
  assign cal       = cal_q;
  assign res_a     = ra_q;
  assign res_b     = rb_q;
  assign res_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_PWR;
      cnt     <= '0;
      div     <= '0;
      h       <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      cal_q   <= 1'b0;
      valid_q <= 1'b0;
      din_sr  <= '0;
      sh_a    <= '0;
      sh_b    <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        S_PWR: begin
          if (cnt == PWRUP_M1) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: begin
          if (cal_req) begin
            st    <= S_CALH;
            cal_q <= 1'b1;
            cnt   <= '0;
          end else if (start) begin
            st     <= S_FRAME;
            cs_q   <= 1'b0;
            div    <= '0;
            h      <= '0;
            din_sr <= DIN_WORD;
          end
        end
        S_CALH: begin
          if (cnt == CALH_M1) begin
            st    <= S_CALG;
            cal_q <= 1'b0;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CALG: begin
          if (cnt == CALG_M1) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_FRAME: begin
          if (!tick) div <= div + 1'b1;
          else begin
            div <= '0;
            if (h == H_LAST) begin
              st      <= S_GAP;
              cnt     <= '0;
              cs_q    <= 1'b1;
              valid_q <= 1'b1;
              ra_q    <= sh_a;
              rb_q    <= sh_b;
            end else begin
              h      <= h_nx;
              sclk_q <= ~sclk_q;
              if (h[0]) din_sr <= {din_sr[DIN_W-2:0], 1'b0};
              if (cap) begin
                sh_a <= {sh_a[RES_W-2:0], lane_a};
                sh_b <= {sh_b[RES_W-2:0], lane_b};
              end
            end
          end
        end
        S_GAP: begin
          if (cnt == GAP_M1) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_frame_in_powerup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWR) |-> cs_n);

  p_sclk_idles_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_valid_on_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_a) && $stable(res_b)));

  p_din_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !din);

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(cs_n) && $past(cs_n, 2)));

  p_cal_excludes_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal |-> cs_n);

endmodule

// File: tb/sim_dual_lane_adc_reader.sv
module sim_dual_lane_adc_reader;
  localparam int H    = 2;
  localparam int CONV = 19;
  localparam int W    = 14;
  localparam int N    = CONV + W;
  localparam int GAP  = 3;
  localparam int CALH = 10;
  localparam int CALG = 8;
  localparam int PWE  = 40;
  localparam int DW   = 16;
  localparam logic [DW-1:0] DWORD = 16'hB29D;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, cal_req, lane_a, lane_b;
  logic cs_n, sclk, din, cal, res_valid;
  logic [W-1:0] res_a, res_b;

  dual_lane_adc_reader #(
    .RES_W(W), .CONV_SCLKS(CONV), .SCLK_HALF(H), .DIN_W(DW), .DIN_WORD(DWORD),
    .QUIET_CYC(3), .CS_MIN_HIGH_CYC(2), .CAL_HIGH_CYC(CALH), .CAL_GAP_CYC(CALG),
    .PWRUP_INT_CYC(5000), .PWRUP_EXT_CYC(PWE), .USE_INT_REF(1'b0)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cal_req(cal_req),
    .lane_a(lane_a), .lane_b(lane_b), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cal(cal), .res_a(res_a), .res_b(res_b), .res_valid(res_valid)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Converter model: garbage outside the result window (R4), MSB-first bits inside (R5)
  int fall_n = 0;
  logic [W-1:0] smp_a, smp_b;
  logic [W-1:0] qa[$], qb[$];

  initial begin
    lane_a = 1'b0;
    lane_b = 1'b0;
  end

  always @(negedge cs_n) begin
    fall_n = 0;
    smp_a = W'($urandom);
    smp_b = W'($urandom);
    qa.push_back(smp_a);
    qb.push_back(smp_b);
  end

  always @(negedge sclk) if (!cs_n) begin
    fall_n++;
    if (fall_n >= CONV && fall_n < CONV + W) begin
      lane_a = smp_a[W-1-(fall_n-CONV)];
      lane_b = smp_b[W-1-(fall_n-CONV)];
    end else begin
      lane_a = 1'($urandom);
      lane_b = 1'($urandom);
    end
  end

  always @(negedge clk) if (cs_n) begin
    lane_a = 1'($urandom);
    lane_b = 1'($urandom);
  end

  // Reference model: 0 power-up, 1 idle, 2 frame, 3 gap, 4 cal high, 5 cal gap
  int m_mode, m_cnt, m_ft;
  logic e_valid;
  logic [W-1:0] e_ra, e_rb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_ft = 0; e_valid = 1'b0; e_ra = '0; e_rb = '0;
    end else begin
      e_valid = 1'b0;
      case (m_mode)
        0: begin m_cnt++; if (m_cnt == PWE) begin m_mode = 1; m_cnt = 0; end end
        1: if (cal_req) begin m_mode = 4; m_cnt = 0; end
           else if (start) begin m_mode = 2; m_ft = 0; end
        2: begin
          m_ft++;
          if (m_ft == (2 * N + 1) * H) begin
            m_mode = 3; m_cnt = 0; e_valid = 1'b1;
            e_ra = qa.pop_front();
            e_rb = qb.pop_front();
          end
        end
        3: begin m_cnt++; if (m_cnt == GAP) begin m_mode = 1; m_cnt = 0; end end
        4: begin m_cnt++; if (m_cnt == CALH) begin m_mode = 5; m_cnt = 0; end end
        5: begin m_cnt++; if (m_cnt == CALG) begin m_mode = 1; m_cnt = 0; end end
        default: m_mode = 1;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int hh, idx;
    logic e_cs, e_sclk, e_din;
    string tag;
    hh     = m_ft / H;
    idx    = hh / 2;
    e_cs   = (m_mode != 2);
    e_sclk = (m_mode == 2) ? (hh % 2 == 0) : 1'b1;
    e_din  = (m_mode == 2 && idx < DW) ? DWORD[DW-1-idx] : 1'b0;
    case (m_mode)
      0: tag = "R1 cs_n";
      2: tag = "R2 R10 cs_n";
      3: tag = "R8 cs_n";
      4, 5: tag = "R9 cs_n";
      default: tag = "R2 cs_n";
    endcase
    chk(tag, 32'(cs_n), 32'(e_cs));
    chk("R3 sclk", 32'(sclk), 32'(e_sclk));
    chk("R7 din", 32'(din), 32'(e_din));
    chk("R9 cal", 32'(cal), 32'(m_mode == 4));
    chk("R6 res_valid", 32'(res_valid), 32'(e_valid));
    chk("R4 R5 res_a", 32'(res_a), 32'(e_ra));
    chk("R4 R5 res_b", 32'(res_b), 32'(e_rb));
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_cal();
    @(negedge clk) cal_req = 1'b1;
    @(negedge clk) cal_req = 1'b0;
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!res_valid) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cal_req = 1'b0;
    idle(3);
    // R1: reset state
    chk("R1 reset cs_n", 32'(cs_n), 32'd1);
    chk("R1 reset sclk", 32'(sclk), 32'd1);
    chk("R1 reset din", 32'(din), 32'd0);
    chk("R1 reset cal", 32'(cal), 32'd0);
    chk("R1 reset res_valid", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    idle(5);
    pulse_start();                 // R1: ignored during power-up
    pulse_cal();                   // R1: ignored during power-up
    idle(PWE);
    pulse_start();                 // first frame
    idle(60);
    pulse_start();                 // R10: start during frame
    pulse_cal();                   // R10: cal during frame
    wait_valid();
    start = 1'b1;                  // R8: held across the quiet gap
    wait_valid();
    wait_valid();
    start = 1'b0;
    idle(10);
    pulse_cal();                   // R9
    idle(3);
    pulse_start();                 // ignored in cal high
    idle(CALH);
    pulse_start();                 // ignored or accepted at cal gap edge
    idle(CALG + 5);
    @(negedge clk) begin start = 1'b1; cal_req = 1'b1; end   // R9: cal wins
    @(negedge clk) begin start = 1'b0; cal_req = 1'b0; end
    idle(CALH + CALG + 5);
    for (int i = 0; i < 8; i++) begin
      pulse_start();
      wait_valid();
      idle($urandom_range(0, 6));
    end
    idle(20);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end
endmodule